// File: doc/BRIEF.md
# Synchronous SRAM Bank Bus Controller

This block connects one bank of 32-bit synchronous SRAM to a 32-bit processor bus that uses dynamic bus sizing. It compares the address against a fixed bank window. For writes it works out which of the four byte lanes the transfer covers and pulls the matching active-low write selects low. For reads it opens the data buffers. The SRAM chip enable is tied permanently active, so the read select only drives the buffers.

The block also drives an active-low synchronous termination output. On a read it asserts in the same clock period as the address strobe. On a write it waits for a registered copy of the strobe, which adds one clock. The result is a two-clock read and a three-clock write, and the extra clock gives the write data time to settle before the write strobes release. Every output is gated by the address strobe and by reset, so nothing asserts before the address is valid.

Top module: `sram_bank_ctrl`

## Requirements
- R1: The bank hits only when address bits 16, 17 and 18 are all 0 and bit 30 is 1. On a miss, every output stays high.
- R2: `lane_we_no[3]` drives data bits 31:24, `[2]` drives 23:16, `[1]` drives 15:8 and `[0]` drives 7:0.
  - The byte offset is `addr_i[1:0]`.
  - `siz_i` encodes the transfer length: 01 = 1 byte, 10 = 2 bytes, 11 = 3 bytes, 00 = 4 bytes.
  - Byte k (k = 0 on lane 3) is written when offset <= k <= offset + length - 1, with k capped at 3.
- R3: The lane selects assert only on write cycles (`rw_i` = 0). During a read they all stay high.
- R4: While `as_ni` is high, every output is high.
- R5: `rd_en_no` is low exactly when `as_ni` is low, `rw_i` is 1 and the bank hits.
- R6: On a bank read, `term_no` goes low in the same clock period in which `as_ni` first goes low.
- R7: On a bank write, `term_no` stays high until the first rising clock edge with the strobe asserted. From then until the strobe negates, it is low.
- R8: The delayed strobe clears after one rising edge with the strobe negated. Every write, including back-to-back writes, therefore takes the extra clock.
- R9: While `rst_ni` is low, every output is high, whatever the bus inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| as_ni | input | 1 | Address strobe, active low |
| rw_i | input | 1 | 1 = read, 0 = write |
| siz_i | input | 2 | Transfer size code |
| addr_i | input | 32 | Bus address |
| lane_we_no | output | 4 | Byte-lane write selects, active low |
| rd_en_no | output | 1 | Read data-buffer enable, active low |
| term_no | output | 1 | Synchronous cycle termination, active low |

## Verification
Most of the block is combinational, so a wrong lane term or a wrong decode appears at the ports in the same clock period as the strobe. The only state is the delayed strobe. If it fails to clear, the next write terminates one clock early, within the first period of that cycle. If it fails to set, the write never terminates. Back-to-back writes with a single idle edge between them are the sharpest probe for that register.

// File: rtl/sram_bank_pkg.sv
package sram_bank_pkg;
  typedef enum logic [1:0] {
    SZ_QUAD   = 2'b00,
    SZ_BYTE   = 2'b01,
    SZ_PAIR   = 2'b10,
    SZ_TRIPLE = 2'b11
  } xfer_size_e;

  localparam int unsigned LANES = 4;

  function automatic logic [2:0] xfer_len(input logic [1:0] siz);
    unique case (xfer_size_e'(siz))
      SZ_BYTE:   xfer_len = 3'd1;
      SZ_PAIR:   xfer_len = 3'd2;
      SZ_TRIPLE: xfer_len = 3'd3;
      default:   xfer_len = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/sram_bank_decode.sv
module sram_bank_decode #(
  parameter int unsigned AW        = 32,
  parameter logic [AW-1:0] BANK_MASK  = 32'h4007_0000,
  parameter logic [AW-1:0] BANK_MATCH = 32'h4000_0000
) (
  input  logic [AW-1:0] addr_i,
  output logic          hit_o
);
  assign hit_o = ((addr_i & BANK_MASK) == BANK_MATCH);
endmodule

// File: rtl/sram_lane_sel.sv
module sram_lane_sel
  import sram_bank_pkg::*;
(
  input  logic [1:0]       off_i,
  input  logic [1:0]       siz_i,
  output logic [LANES-1:0] lanes_o
);
  localparam int unsigned SW = $clog2(LANES) + 2;

  logic [SW-1:0] first_b, last_b;

  always_comb begin
    first_b = SW'(off_i);
    last_b  = SW'(off_i) + SW'(xfer_len(siz_i)) - SW'(1);
  end

  // byte k maps to lane LANES-1-k (k=0 is the most significant lane)
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lanes_o[LANES-1-k] = (SW'(k) >= first_b) && (SW'(k) <= last_b);
  end
endmodule

// File: rtl/sram_term_gen.sv
module sram_term_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic as_act_i,
  input  logic sel_i,
  input  logic rw_i,
  output logic term_no
);
  logic das_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) das_q <= 1'b0;
    else         das_q <= as_act_i;
  end

  assign term_no = !(sel_i && (rw_i || das_q));

  logic wr_sel;
  assign wr_sel = sel_i && !rw_i;

  // R7: an ongoing write terminates from the second sampled edge onward
  p_wr_held_term_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wr_sel) && $past(as_act_i) && wr_sel) |-> !term_no);

  // R8: a freshly asserted strobe never terminates a write at once
  p_wr_first_wait_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(as_act_i) && wr_sel) |-> term_no);

  // R6: reads terminate without waiting
  p_rd_term_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && rw_i) |-> !term_no);
endmodule

// File: rtl/sram_bank_ctrl.sv
module sram_bank_ctrl
  import sram_bank_pkg::*;
#(
  parameter int unsigned   AW         = 32,
  parameter logic [AW-1:0] BANK_MASK  = 32'h4007_0000,
  parameter logic [AW-1:0] BANK_MATCH = 32'h4000_0000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             as_ni,
  input  logic             rw_i,
  input  logic [1:0]       siz_i,
  input  logic [AW-1:0]    addr_i,
  output logic [LANES-1:0] lane_we_no,
  output logic             rd_en_no,
  output logic             term_no
);
  logic             hit, as_act, sel;
  logic [LANES-1:0] lanes;

  sram_bank_decode #(
    .AW(AW), .BANK_MASK(BANK_MASK), .BANK_MATCH(BANK_MATCH)
  ) u_dec (
    .addr_i(addr_i),
    .hit_o (hit)
  );

  sram_lane_sel u_lanes (
    .off_i  (addr_i[1:0]),
    .siz_i  (siz_i),
    .lanes_o(lanes)
  );

  // strobe qualified by reset so outputs idle during reset
  assign as_act = !as_ni && rst_ni;
  assign sel    = as_act && hit;

  assign lane_we_no = ~(lanes & {LANES{sel && !rw_i}});
  assign rd_en_no   = !(sel && rw_i);

  sram_term_gen u_term (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .as_act_i(as_act),
    .sel_i   (sel),
    .rw_i    (rw_i),
    .term_no (term_no)
  );

  p_miss_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |-> (&lane_we_no && rd_en_no && term_no));

  p_rd_no_lane_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rw_i |-> &lane_we_no);

  p_strobe_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    as_ni |-> (&lane_we_no && rd_en_no && term_no));

  p_rd_en_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!as_ni && rw_i && hit) |-> !rd_en_no);

  p_lane_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!as_ni && !rw_i && hit) |-> (lane_we_no != '1));

  always_comb begin
    if (!rst_ni) begin
      p_reset_idle_r9: assert (&lane_we_no && rd_en_no && term_no);
    end
  end
endmodule

// File: tb/sim_sram_bank_ctrl.sv
module sim_sram_bank_ctrl;
  localparam time CLK_P = 10ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        as_ni = 1'b1;
  logic        rw_i = 1'b1;
  logic [1:0]  siz_i = 2'b00;
  logic [31:0] addr_i = 32'h4000_0000;
  logic [3:0]  lane_we_no;
  logic        rd_en_no, term_no;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  sram_bank_ctrl u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .as_ni(as_ni), .rw_i(rw_i),
    .siz_i(siz_i), .addr_i(addr_i),
    .lane_we_no(lane_we_no), .rd_en_no(rd_en_no), .term_no(term_no)
  );

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%b exp=%b t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [5:0] outs();
    return {lane_we_no, rd_en_no, term_no};
  endfunction

  // active-high lane pattern from the length/offset rule
  function automatic logic [3:0] exp_lanes(input logic [1:0] off, input logic [1:0] siz);
    int len;
    logic [3:0] r = 4'b0000;
    len = (siz == 2'b00) ? 4 : int'(siz);
    for (int b = 0; b < 4; b++)
      if (b >= int'(off) && b < int'(off) + len) r[3-b] = 1'b1;
    return r;
  endfunction

  // one bus cycle; strobe asserted at negedge
  task automatic bus_cycle(input string req, input logic [31:0] a, input logic rd,
                           input logic [1:0] siz, input logic in_bank);
    logic [3:0] ln;
    logic [5:0] e1, e2;
    @(negedge clk_i);
    addr_i = a; rw_i = rd; siz_i = siz; as_ni = 1'b0;
    ln = (in_bank && !rd) ? exp_lanes(a[1:0], siz) : 4'b0000;
    e1 = {~ln, !(in_bank && rd), !(in_bank && rd)};
    e2 = {~ln, !(in_bank && rd), !in_bank};
    #(CLK_P/4);
    check(req, outs(), e1);
    @(posedge clk_i); #(CLK_P/4);
    check(req, outs(), e2);
    @(negedge clk_i);
    as_ni = 1'b1;
    #1;
    check("R4", outs(), 6'b111111);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0; as_ni = 1'b0; rw_i = 1'b0; siz_i = 2'b00; addr_i = 32'h4000_0000;
    repeat (2) @(posedge clk_i);
    #1 check("R9 write held in reset", outs(), 6'b111111);
    rw_i = 1'b1;
    #1 check("R9 read held in reset", outs(), 6'b111111);
    @(negedge clk_i); as_ni = 1'b1; rst_ni = 1'b1;
    @(negedge clk_i);
    check("R4 idle after reset", outs(), 6'b111111);
  endtask

  task automatic t_write_sweep();
    for (int o = 0; o < 4; o++)
      for (int s = 0; s < 4; s++)
        bus_cycle("R2 R3 R7 write lanes", 32'h4000_1230 | o, 1'b0, 2'(s), 1'b1);
  endtask

  task automatic t_read_sweep();
    for (int o = 0; o < 4; o++)
      for (int s = 0; s < 4; s++)
        bus_cycle("R3 R5 R6 read", 32'h40F8_0000 | o, 1'b1, 2'(s), 1'b1);
  endtask

  task automatic t_outside();
    logic [31:0] bad_a [4] = '{32'h4001_0000, 32'h4002_0000, 32'h4004_0000, 32'h0000_0000};
    for (int i = 0; i < 4; i++)
      for (int s = 0; s < 4; s++) begin
        bus_cycle("R1 miss write", bad_a[i] | (s & 3), 1'b0, 2'(s), 1'b0);
        bus_cycle("R1 miss read",  bad_a[i] | (s & 3), 1'b1, 2'(s), 1'b0);
      end
  endtask

  // writes separated by a single idle edge still wait one clock
  task automatic t_back_to_back();
    for (int i = 0; i < 3; i++)
      bus_cycle("R8 back-to-back write", 32'h4000_0000, 1'b0, 2'b00, 1'b1);
    bus_cycle("R8 read after write", 32'h4000_0002, 1'b1, 2'b10, 1'b1);
    bus_cycle("R8 write after read", 32'h4000_0002, 1'b0, 2'b10, 1'b1);
  endtask

  task automatic t_reset_mid_write();
    @(negedge clk_i);
    addr_i = 32'h4000_0000; rw_i = 1'b0; siz_i = 2'b00; as_ni = 1'b0;
    @(posedge clk_i); #(CLK_P/4);
    check("R7 held write", outs(), 6'b000010);
    rst_ni = 1'b0;
    #1 check("R9 reset mid write", outs(), 6'b111111);
    @(negedge clk_i); as_ni = 1'b1; rst_ni = 1'b1;
    bus_cycle("R8 write after reset", 32'h4000_0001, 1'b0, 2'b01, 1'b1);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_write_sweep();
    t_read_sweep();
    t_outside();
    t_back_to_back();
    t_reset_mid_write();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule